// File: doc/BRIEF.md
# Six-bit pseudo-LRU replacement state

This block keeps the replacement history of a four-way set-associative cache, one six-bit record per set. Each record holds the relative age of every pair of ways: one bit per pair, telling which way of the pair was touched more recently. The record is updated when a way of the set is touched: on a read hit, on a write hit, and for the way filled after a read miss. The block also names the way to evict from the addressed set.

The victim is combinational from the stored record of the set on `set_idx`. An update strobed in a cycle lands on the next rising clock edge. A mode input narrows the choice to the upper way pair only, for a cache that runs with half its ways. A synchronous clear input returns every record to zero, as reset does.

Top module: `plru6_replace`

## Requirements
- R1: An update of way 0 (`acc_way` = 0) clears bits 5, 4 and 3 of the addressed record and keeps its other bits.
- R2: An update of way 1 sets bit 5 and clears bits 2 and 1 of the addressed record, keeping the rest.
- R3: An update of way 2 sets bits 4 and 2 and clears bit 0 of the addressed record, keeping the rest.
- R4: An update of way 3 sets bits 3, 1 and 0 of the addressed record, keeping the rest.
- R5: With `pair_mode` low, `victim` is the binary way number picked in priority order, lowest way first. Way 0 is picked when bits 5, 4 and 3 are all 1. Way 1 is picked when bit 5 is 0 and bits 2 and 1 are 1. Way 2 is picked when bits 4 and 2 are 0 and bit 0 is 1. Way 3 is picked when bits 3, 1 and 0 are 0. If none of these matches, the result is way 0. For every reachable record this is the least recently touched way.
- R6: With `pair_mode` high, `victim` is 2 when bit 0 of the record is 1 and 3 when it is 0, so it is the less recently touched of ways 2 and 3.
- R7: `clr` high at a rising edge sets all records to zero and takes priority over an update in the same cycle. Afterwards `victim` is 3 for every set in both modes.
- R8: After a synchronous active-low reset, every record is zero and `victim` is 3 for every set.
- R9: With `upd_en` low, no record changes, whatever `acc_way` and `set_idx` are. An update changes only the record on `set_idx`.
- R10: `victim` follows `set_idx` and `pair_mode` in the same cycle. During an update cycle it shows the record as it was before that update. The new record is visible after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| set_idx | input | 6 | Set addressed for update and victim lookup |
| acc_way | input | 2 | Way touched, as a binary way number |
| upd_en | input | 1 | Apply the touch of `acc_way` to the addressed set at the next edge |
| pair_mode | input | 1 | High: choose the victim between ways 2 and 3 only |
| clr | input | 1 | Zero all records at the next edge |
| victim | output | 2 | Way to evict from the addressed set |

## Verification
The checker compares the victim after an edge with the touch made at that edge. It does so only when `set_idx` and `pair_mode` were held across the edge. The checker also assumes the inputs are never unknown outside reset. The bench changes every input half a period after the rising edge and holds it through the next edge. It sweeps set indices, modes, clears and strobes, so the held-input cases arise often and the changed-input cases exercise the combinational lookup.

// File: rtl/plru6_pkg.sv
// plru6_pkg: shared types and encoding tables for the six-bit pairwise-age
// replacement record. Bit meaning (1 = second way of the pair is newer):
//   bit5: 0/1, bit4: 0/2, bit3: 0/3, bit2: 1/2, bit1: 1/3, bit0: 2/3.
// Assumes exactly four ways; the tables below are fixed to that count.
package plru6_pkg;

    localparam int STATE_W = 6;
    localparam int NUM_WAYS = 4;
    localparam int WAY_W = $clog2(NUM_WAYS);

    typedef logic [STATE_W-1:0] age_rec_t;
    typedef logic [WAY_W-1:0]   way_t;

    // Bits forced to one when the given way is touched.
    function automatic age_rec_t touch_set_mask(input way_t w);
        case (w)
            2'd0:    return 6'b000000;
            2'd1:    return 6'b100000;
            2'd2:    return 6'b010100;
            default: return 6'b001011;
        endcase
    endfunction

    // Bits forced to zero when the given way is touched.
    function automatic age_rec_t touch_clr_mask(input way_t w);
        case (w)
            2'd0:    return 6'b111000;
            2'd1:    return 6'b000110;
            2'd2:    return 6'b000001;
            default: return 6'b000000;
        endcase
    endfunction

    // Bits examined when testing whether the given way is oldest.
    function automatic age_rec_t oldest_care(input way_t w);
        case (w)
            2'd0:    return 6'b111000;
            2'd1:    return 6'b100110;
            2'd2:    return 6'b010101;
            default: return 6'b001011;
        endcase
    endfunction

    // Required values of the examined bits for the given way to be oldest.
    function automatic age_rec_t oldest_want(input way_t w);
        case (w)
            2'd0:    return 6'b111000;
            2'd1:    return 6'b000110;
            2'd2:    return 6'b000001;
            default: return 6'b000000;
        endcase
    endfunction

endpackage

// File: rtl/plru6_rec_bank.sv
// plru6_rec_bank: storage of one age record per set with one read port and
// one write port. Reset and clear are synchronous and zero every record;
// clear has priority over the write. Assumes rd/wr indices are below SETS.
module plru6_rec_bank
    import plru6_pkg::*;
#(
    parameter int SETS  = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  age_rec_t         wr_rec,
    input  logic [IDX_W-1:0] rd_idx,
    output age_rec_t         rd_rec
);

    age_rec_t recs [SETS];

    // Record storage: zero on reset or clear, else write the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int s = 0; s < SETS; s++) begin
                recs[s] <= '0;
            end
        end else if (wr_en) begin
            recs[wr_idx] <= wr_rec;
        end
    end

    // Read port: combinational lookup of the addressed record.
    always_comb begin
        rd_rec = recs[rd_idx];
    end

endmodule

// File: rtl/plru6_touch.sv
// plru6_touch: next value of an age record after a way is touched.
// Pure combinational; the clear mask is applied before the set mask.
module plru6_touch
    import plru6_pkg::*;
(
    input  age_rec_t cur_rec,
    input  way_t     way,
    output age_rec_t nxt_rec
);

    // Apply the per-way clear and set masks to the current record.
    always_comb begin
        nxt_rec = (cur_rec & ~touch_clr_mask(way)) | touch_set_mask(way);
    end

endmodule

// File: rtl/plru6_pick.sv
// plru6_pick: victim choice from one age record. In full mode the lowest
// way whose oldest pattern matches wins, and way 0 is the fallback when no
// pattern matches. In pair mode only bit 0 decides, between ways 2 and 3.
module plru6_pick
    import plru6_pkg::*;
(
    input  age_rec_t rec,
    input  logic     pair_mode,
    output way_t     victim
);

    logic [NUM_WAYS-1:0] is_oldest;
    way_t                full_pick;

    // One pattern comparator per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_match
        assign is_oldest[w] = ((rec & oldest_care(way_t'(w))) == oldest_want(way_t'(w)));
    end

    // Priority encode the matches, lowest way first, default way 0.
    always_comb begin
        full_pick = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (is_oldest[w]) begin
                full_pick = way_t'(w);
            end
        end
    end

    // Mode select between the full choice and the upper-pair choice.
    always_comb begin
        if (pair_mode) begin
            victim = rec[0] ? way_t'(2) : way_t'(3);
        end else begin
            victim = full_pick;
        end
    end

endmodule

// File: rtl/plru6_replace.sv
// plru6_replace: per-set six-bit pseudo-LRU replacement state.
// A strobed touch rewrites the addressed record at the rising edge; the
// victim of the addressed set is combinational from the stored record, so
// during an update cycle it still shows the record before that update.
// Assumes acc_way is a valid way number and set_idx is below SETS.
module plru6_replace
    import plru6_pkg::*;
#(
    parameter int SETS  = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             upd_en,
    input  logic             pair_mode,
    input  logic             clr,
    output logic [WAY_W-1:0] victim
);

    age_rec_t cur_rec;
    age_rec_t nxt_rec;

    plru6_rec_bank #(.SETS(SETS)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_en  (upd_en),
        .wr_idx (set_idx),
        .wr_rec (nxt_rec),
        .rd_idx (set_idx),
        .rd_rec (cur_rec)
    );

    plru6_touch touch_i (
        .cur_rec (cur_rec),
        .way     (acc_way),
        .nxt_rec (nxt_rec)
    );

    plru6_pick pick_i (
        .rec       (cur_rec),
        .pair_mode (pair_mode),
        .victim    (victim)
    );

endmodule

// File: rtl/plru6_replace_chk.sv
// plru6_replace_chk: protocol-level checks on the replacement block, bound
// to every instance of plru6_replace. Observes ports only.
module plru6_replace_chk #(
    parameter int SETS  = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] set_idx,
    input logic [1:0]       acc_way,
    input logic             upd_en,
    input logic             pair_mode,
    input logic             clr,
    input logic [1:0]       victim
);

    // R8: the first cycle out of reset sees all records zero.
    a_r8_reset_victim: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> victim == 2'd3);

    // R7: after a clear every set yields way 3.
    a_r7_clear_victim: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> victim == 2'd3);

    // R5: the way just touched is never the full-mode victim of that set.
    a_r5_not_recent: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr) |=> (($stable(set_idx) && !pair_mode) -> victim != $past(acc_way)));

    // R4, R6: touching way 3 makes way 2 the pair-mode victim.
    a_r4_pair_after_w3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && acc_way == 2'd3) |=> (($stable(set_idx) && pair_mode) -> victim == 2'd2));

    // R3, R6: touching way 2 makes way 3 the pair-mode victim.
    a_r3_pair_after_w2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !clr && acc_way == 2'd2) |=> (($stable(set_idx) && pair_mode) -> victim == 2'd3));

    // R9: without a strobe or clear the victim of a held set stays put.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !clr) |=> (($stable(set_idx) && $stable(pair_mode)) -> $stable(victim)));

    // R6: pair mode never names way 0 or 1.
    a_r6_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
        pair_mode |-> victim[1]);

endmodule

bind plru6_replace plru6_replace_chk #(.SETS(SETS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_idx   (set_idx),
    .acc_way   (acc_way),
    .upd_en    (upd_en),
    .pair_mode (pair_mode),
    .clr       (clr),
    .victim    (victim)
);

// File: tb/plru6_replace_tb_top.sv
`timescale 1ns/1ps
// Bench: a recency-rank model per set (0 = most recent) is stepped each
// clock and the victim is compared before every rising edge.
module plru6_replace_tb_top;

    localparam int SETS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] set_idx = '0;
    logic [1:0] acc_way = '0;
    logic       upd_en = 1'b0;
    logic       pair_mode = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] victim;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int rank [SETS][4];

    always #2.5 clk = ~clk;

    plru6_replace #(.SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_way(acc_way),
        .upd_en(upd_en), .pair_mode(pair_mode), .clr(clr), .victim(victim)
    );

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < 4; w++)
                rank[s][w] = w;
    endtask

    task automatic model_touch(input int s, input int w);
        for (int o = 0; o < 4; o++)
            if (rank[s][o] < rank[s][w]) rank[s][o] = rank[s][o] + 1;
        rank[s][w] = 0;
    endtask

    function automatic int model_victim(input int s, input bit pm);
        int v;
        v = 0;
        if (pm) v = (rank[s][2] > rank[s][3]) ? 2 : 3;
        else for (int w = 0; w < 4; w++) if (rank[s][w] == 3) v = w;
        return v;
    endfunction

    // One cycle: drive after the falling edge, compare, then step the model.
    task automatic step(input int s, input int w, input bit up, input bit pm,
                        input bit cl, input string req);
        int exp_v;
        @(negedge clk);
        set_idx = 6'(s); acc_way = 2'(w); upd_en = up; pair_mode = pm; clr = cl;
        #1;
        exp_v = model_victim(s, pm);
        checks++;
        if (int'(victim) != exp_v) begin
            errors++;
            $display("FAIL %s set=%0d victim=%0d expected=%0d", req, s, victim, exp_v);
        end
        if (cl) model_reset();
        else if (up) model_touch(s, w);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R8: reset state in both modes
        step(0, 0, 0, 0, 0, "R8");
        step(63, 0, 0, 1, 0, "R8");
        step(17, 2, 0, 0, 0, "R8");
        // R4 then R3: touch way 3, then way 2, read back in both modes
        step(1, 3, 1, 0, 0, "R4");
        step(1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 1, 0, "R4");
        step(1, 2, 1, 0, 0, "R3");
        step(1, 0, 0, 1, 0, "R3");
        step(1, 0, 0, 0, 0, "R3");
        // R2, R1: touch way 1 and way 0 on another set
        step(2, 1, 1, 0, 0, "R2");
        step(2, 0, 0, 0, 0, "R2");
        step(2, 0, 1, 0, 0, "R1");
        step(2, 0, 0, 0, 0, "R1");
        // R5: fill order 3,2,1,0 then touch victims repeatedly
        for (int w = 3; w >= 0; w--) step(3, w, 1, 0, 0, "R5");
        for (int i = 0; i < 8; i++) step(3, model_victim(3, 0), 1, 0, 0, "R5");
        // R6: pair mode over a mix of touches
        for (int i = 0; i < 8; i++) step(4, i % 4, 1, 1, 0, "R6");
        // R9: no strobe, acc_way and set moving; then other sets unchanged
        for (int i = 0; i < 8; i++) step(3, i % 4, 0, 0, 0, "R9");
        step(5, 1, 1, 0, 0, "R9");
        step(3, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        // R10: set index changes every cycle, victim follows at once
        for (int i = 0; i < 6; i++) step(i, 0, 0, i % 2, 0, "R10");
        step(3, 2, 1, 0, 0, "R10");
        step(3, 0, 0, 0, 0, "R10");
        // R7: clear with a simultaneous update, then sweep sets
        step(3, 1, 1, 0, 1, "R7");
        for (int s = 0; s < 6; s++) step(s, 0, 0, s % 2, 0, "R7");
        // R5/R6 mixed random traffic with rare clears
        for (int i = 0; i < 3000; i++) begin
            int s;
            s = ($urandom % 9 == 0) ? 63 : int'($urandom % 8);
            step(s, int'($urandom % 4), ($urandom % 4) != 0, ($urandom % 3) == 0,
                 ($urandom % 300) == 0, "R5");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule